// File: doc/BRIEF.md
# Double-Buffered PWM Timer

The block is an 8-bit up-counter that turns a compare value into a pulse-width-modulated output. The counter starts at zero and advances once for each cycle on which an external prescaler raises the tick enable. It wraps after 2^n ticks, where n is 6, 7 or 8 as chosen through a mode write. The output is a toggle flip-flop. It flips when the counter steps onto the compare value and flips again at the wrap. After the flip-flop is cleared, each period is therefore low for c ticks and high for the remaining 2^n − c ticks.

The compare value can be double-buffered. In that case a write only fills a holding register. The active compare value is loaded from the holding register at the next wrap, so a write made in the middle of a period never cuts or stretches the pulse in progress. Without buffering, a write takes effect on the next clock. A control write arms or disarms the toggling, selects buffering and can clear the flip-flop. A run input starts and stops counting, and a stop returns the counter to zero.

A two-state run machine governs counting. In `ST_STOP` the counter is held at zero. The transition `ST_STOP → ST_COUNT` is taken when run is high. In `ST_COUNT` the counter advances on ticks while run stays high. The transition `ST_COUNT → ST_STOP` is taken when run is low.

Top module: `dbpwm_timer`

## Requirements
- R1: After reset the output is 0, n is 8, toggling and buffering are disabled and the active compare value is 0.
- R2: A mode write selects the period length through `mode_wdata`: value 0 gives n=6, value 1 gives n=7, and values 2 and 3 give n=8. The period of the output is then 2^n ticks.
- R3: With toggling enabled, the output flips on the tick at which the counter steps to the compare value c (1 ≤ c < 2^n) and again on the wrap. After a clear, every period is low for c ticks and high for 2^n − c ticks.
- R4: With toggling disabled (`ctrl_wdata` bit 0 written as 0), the output holds its level while the counter runs.
- R5: A control write with `ctrl_wdata` bit 2 set forces the output to 0 on the next clock edge, and this overrides any toggle.
- R6: Driving run low clears the counter. When run is raised again with the output cleared, the first rising edge of the output appears c+1 clock cycles after the cycle on which run was driven high.
- R7: The counter changes only on cycles with `tick_en` high. With ticks on every other cycle, every width doubles. With no ticks, the output does not change.
- R8: With buffering disabled (`ctrl_wdata` bit 1 written as 0), a compare write becomes active on the next clock and already governs the period in progress.
- R9: With buffering enabled (`ctrl_wdata` bit 1 written as 1), a compare write leaves the current period unchanged, and the new value governs the period that follows the next wrap.
- R10: When a compare step and a wrap fall on the same tick, the output flips only once. With n=8 and c=0 the output is a square wave of 256 ticks high and 256 ticks low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaler tick; the counter advances only when high |
| run | input | 1 | High to count; low stops counting and clears the counter |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Period select (0: 2^6, 1: 2^7, 2 or 3: 2^8) |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 3 | Bit 0 toggle enable, bit 1 buffer enable, bit 2 clear output |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | 8 | Compare value |
| pwm_out | output | 1 | PWM output |

## Verification
The bench sweeps every compare value for the shortest period and a spread of values for the two longer ones. It measures low width, high width and rise-to-rise period against c, 2^n − c and 2^n. An off-by-one in the compare timing would shift every low width by one tick. A wrong wrap mask would stretch the period. A compare update is written five ticks into a low phase, both raising and lowering the value, in each buffering mode. A design that commits a buffered write early would cut the current pulse, and one that buffers an unbuffered write would delay it by a period. The remaining targets are the stop-and-restart delay, which exposes a counter that is not cleared, and the coincident compare-and-wrap case, where applying both toggles would freeze the output. Halved and absent ticks, the frozen output with toggling off, and the clear are also checked.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
    typedef enum logic {
        ST_STOP  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

    localparam int SEL_W    = 2;
    localparam int CTRL_W   = 3;
    localparam int CTRL_INV = 0;
    localparam int CTRL_BUF = 1;
    localparam int CTRL_CLR = 2;
endpackage

// File: rtl/dbpwm_counter.sv
module dbpwm_counter
    import dbpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] len_sel,
    output logic [CW-1:0]    cnt,
    output logic [CW-1:0]    cnt_step,
    output logic             adv,
    output logic             wrap
);
    localparam logic [CW-1:0] MASK_SHORT = {2'b00, {(CW-2){1'b1}}};
    localparam logic [CW-1:0] MASK_MID   = {1'b0, {(CW-1){1'b1}}};
    localparam logic [CW-1:0] MASK_FULL  = {CW{1'b1}};

    run_state_e    state_q, state_d;
    logic [CW-1:0] mask;

    always_comb begin
        case (len_sel)
            2'd0:    mask = MASK_SHORT;
            2'd1:    mask = MASK_MID;
            default: mask = MASK_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_STOP;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (run)  state_d = ST_COUNT;
            ST_COUNT: if (!run) state_d = ST_STOP;
        endcase
    end

    always_comb begin
        adv = 1'b0;
        unique case (state_q)
            ST_STOP:  adv = 1'b0;
            ST_COUNT: adv = run && tick_en;
        endcase
    end

    assign cnt_step = cnt + 1'b1;
    assign wrap     = adv && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (wrap)    cnt <= '0;
        else if (adv)     cnt <= cnt_step;
    end

    // R6: a low run leaves the counter at zero
    a_r6_stop_clears: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    // R2: the wrap returns the counter to zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

    // R7: without a tick the count is frozen
    a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !tick_en) |=> $stable(cnt));
endmodule

// File: rtl/dbpwm_cmpreg.sv
module dbpwm_cmpreg #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          buf_en,
    input  logic          commit,
    output logic [CW-1:0] active
);
    logic [CW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)        hold_q <= '0;
        else if (wr_en) hold_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)                    active <= '0;
        else if (wr_en && !buf_en)  active <= wr_data;
        else if (commit && buf_en)  active <= hold_q;
    end

    // R9: buffered, the active value moves only at a wrap
    a_r9_buffered_hold: assert property (@(posedge clk) disable iff (rst)
        (buf_en && !commit) |=> $stable(active));

    // R8: unbuffered, a write lands on the next edge
    a_r8_direct_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !buf_en) |=> (active == $past(wr_data)));
endmodule

// File: rtl/dbpwm_outff.sv
module dbpwm_outff (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inv_en,
    input  logic wrap,
    input  logic match,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr)            q <= 1'b0;
        else if (inv_en && wrap)   q <= ~q;
        else if (inv_en && match)  q <= ~q;
    end

    // R5: a clear wins over any toggle
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> !q);

    // R4: toggling disabled keeps the level
    a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
        (!inv_en && !clr) |=> $stable(q));

    // R10: a wrap flips exactly once, even with a coincident match
    a_r10_single_flip: assert property (@(posedge clk) disable iff (rst)
        (inv_en && !clr && wrap) |=> (q != $past(q)));
endmodule

// File: rtl/dbpwm_timer.sv
module dbpwm_timer
    import dbpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              run,
    input  logic              mode_we,
    input  logic [SEL_W-1:0]  mode_wdata,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              cmp_we,
    input  logic [CW-1:0]     cmp_wdata,
    output logic              pwm_out
);
    logic [SEL_W-1:0] len_sel_q;
    logic             inv_q;
    logic             buf_q;
    logic             clr;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    cnt_step;
    logic [CW-1:0]    cmp_active;
    logic             adv;
    logic             wrap;
    logic             match;

    always_ff @(posedge clk) begin
        if (rst)          len_sel_q <= 2'd2;
        else if (mode_we) len_sel_q <= mode_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_q <= 1'b0;
            buf_q <= 1'b0;
        end else if (ctrl_we) begin
            inv_q <= ctrl_wdata[CTRL_INV];
            buf_q <= ctrl_wdata[CTRL_BUF];
        end
    end

    assign clr   = ctrl_we && ctrl_wdata[CTRL_CLR];
    assign match = adv && (cnt_step == cmp_active);

    dbpwm_counter #(.CW(CW)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick_en  (tick_en),
        .len_sel  (len_sel_q),
        .cnt      (cnt),
        .cnt_step (cnt_step),
        .adv      (adv),
        .wrap     (wrap)
    );

    dbpwm_cmpreg #(.CW(CW)) u_cmpreg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmp_we),
        .wr_data (cmp_wdata),
        .buf_en  (buf_q),
        .commit  (wrap),
        .active  (cmp_active)
    );

    dbpwm_outff u_outff (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .inv_en (inv_q),
        .wrap   (wrap),
        .match  (match),
        .q      (pwm_out)
    );

    // R3: a compare step away from the wrap flips the output
    a_r3_match_flips: assert property (@(posedge clk) disable iff (rst)
        (inv_q && !clr && match && !wrap) |=> (pwm_out != $past(pwm_out)));

    // R1: the first cycle out of reset has a low output
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !pwm_out);
endmodule

// File: tb/test_dbpwm_timer.sv
`timescale 1ns/1ps
module test_dbpwm_timer;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       run = 1'b0;
    logic       mode_we = 1'b0;
    logic [1:0] mode_wdata = 2'd0;
    logic       ctrl_we = 1'b0;
    logic [2:0] ctrl_wdata = 3'd0;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic       pwm_out;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int n_rise = 0, n_fall = 0;
    int t_rise = 0, t_fall = 0;
    int last_low = 0, last_high = 0, last_per = 0;
    logic prev = 1'b0;
    logic half = 1'b0;
    logic tick_off = 1'b0;

    always #10 clk = ~clk;

    dbpwm_timer i_dbpwm_timer (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .run        (run),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .cmp_we     (cmp_we),
        .cmp_wdata  (cmp_wdata),
        .pwm_out    (pwm_out)
    );

    always @(negedge clk) begin
        if (tick_off)  tick_en <= 1'b0;
        else if (half) tick_en <= ~tick_en;
        else           tick_en <= 1'b1;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (pwm_out && !prev) begin
                n_rise   = n_rise + 1;
                last_low = cyc - t_fall;
                last_per = cyc - t_rise;
                t_rise   = cyc;
            end else if (!pwm_out && prev) begin
                n_fall    = n_fall + 1;
                last_high = cyc - t_rise;
                t_fall    = cyc;
            end
        end
        prev = pwm_out;
        if (cyc == WD_LIMIT) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog (R1..R10 run): actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors = vectors + 1;
        if (act != exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [1:0] v);
        @(negedge clk); mode_we = 1'b1; mode_wdata = v;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [2:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_cmp(input logic [7:0] v);
        @(negedge clk); cmp_we = 1'b1; cmp_wdata = v;
        @(negedge clk); cmp_we = 1'b0;
    endtask

    task automatic wait_rise(input int tgt);
        wait (n_rise >= tgt);
    endtask

    // stop, clear, program and restart; returns after two rises
    task automatic setup(input logic [1:0] msel, input int c, input bit dbuf);
        int r0;
        @(negedge clk); run = 1'b0;
        wr_mode(msel);
        wr_ctrl(3'b101);
        wr_cmp(c[7:0]);
        if (dbuf) wr_ctrl(3'b011);
        @(negedge clk); run = 1'b1;
        r0 = n_rise;
        wait_rise(r0 + 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 output after reset", int'(pwm_out), 0);

        // R1: toggling is disabled out of reset
        @(negedge clk); run = 1'b1;
        repeat (600) @(negedge clk);
        chk("R1 no edges with default toggle off", n_rise + n_fall, 0);

        // R1: default n is 8
        wr_cmp(8'd100);
        wr_ctrl(3'b101);
        begin
            int r0;
            r0 = n_rise;
            wait_rise(r0 + 2);
        end
        chk("R1 default period", last_per, 256);
        chk("R1 default low width", last_low, 100);
        chk("R1 default high width", last_high, 156);

        // R2 R3: full sweep for n=6
        for (int c = 1; c < 64; c++) begin
            setup(2'd0, c, 1'b0);
            chk("R3 low width n=6", last_low, c);
            chk("R3 high width n=6", last_high, 64 - c);
            chk("R2 period n=6", last_per, 64);
        end
        // R2 R3: spread for n=7
        for (int c = 1; c < 128; c += 5) begin
            setup(2'd1, c, 1'b0);
            chk("R3 low width n=7", last_low, c);
            chk("R3 high width n=7", last_high, 128 - c);
            chk("R2 period n=7", last_per, 128);
        end
        // R2 R3: spread for n=8, mode values 2 and 3
        for (int c = 3; c < 256; c += 17) begin
            setup((c % 2 == 1) ? 2'd3 : 2'd2, c, 1'b0);
            chk("R3 low width n=8", last_low, c);
            chk("R3 high width n=8", last_high, 256 - c);
            chk("R2 period n=8", last_per, 256);
        end

        // R6: stop mid-count, clear, restart
        setup(2'd1, 30, 1'b0);
        repeat (50) @(negedge clk);
        @(negedge clk); run = 1'b0;
        wr_ctrl(3'b101);
        begin
            int k;
            @(negedge clk); run = 1'b1;
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!pwm_out && k < 400);
            chk("R6 first rise after restart", k, 31);
        end

        // R7: ticks every other cycle
        setup(2'd0, 20, 1'b0);
        half = 1'b1;
        begin
            int r0;
            r0 = n_rise;
            wait_rise(r0 + 2);
        end
        chk("R7 low width halved ticks", last_low, 40);
        chk("R7 high width halved ticks", last_high, 88);
        chk("R7 period halved ticks", last_per, 128);
        half = 1'b0;

        // R7: no ticks, no edges
        setup(2'd0, 20, 1'b0);
        tick_off = 1'b1;
        begin
            int e0;
            @(negedge clk);
            e0 = n_rise + n_fall;
            repeat (300) @(negedge clk);
            chk("R7 no edges without ticks", n_rise + n_fall - e0, 0);
        end
        tick_off = 1'b0;

        // R4: toggling disabled while high
        setup(2'd0, 10, 1'b0);
        wr_ctrl(3'b000);
        begin
            int e0;
            e0 = n_rise + n_fall;
            repeat (200) @(negedge clk);
            chk("R4 no edges with toggle off", n_rise + n_fall - e0, 0);
            chk("R4 level held high", int'(pwm_out), 1);
        end
        // R5: clear forces zero
        wr_ctrl(3'b100);
        chk("R5 output after clear", int'(pwm_out), 0);

        // R8 R9: compare rewrite five ticks into a low phase
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 2; p++) begin
                int c1, c2, f0, r0;
                c1 = (p == 0) ? 40 : 20;
                c2 = (p == 0) ? 20 : 60;
                setup(2'd1, c1, b[0]);
                f0 = n_fall;
                wait (n_fall >= f0 + 1);
                repeat (4) @(negedge clk);
                r0 = n_rise;
                wr_cmp(c2[7:0]);
                wait_rise(r0 + 1);
                if (b == 0) chk("R8 unbuffered write hits current period", last_low, c2);
                else        chk("R9 buffered write spares current period", last_low, c1);
                wait_rise(r0 + 2);
                if (b == 0) chk("R8 unbuffered high width", last_high, 128 - c2);
                else        chk("R9 high width before commit", last_high, 128 - c1);
                if (b == 0) chk("R8 next period low width", last_low, c2);
                else        chk("R9 next period uses new value", last_low, c2);
            end
        end

        // R10: compare step coincides with the wrap
        setup(2'd2, 0, 1'b0);
        chk("R10 low width coincident", last_low, 256);
        chk("R10 high width coincident", last_high, 256);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule